// File: doc/BRIEF.md
# Sv39 Page Table Walker

This block resolves a 39-bit virtual address into a 56-bit physical address by walking a three-level page table held in memory. A client raises a one-cycle request that carries the virtual address, the kind of access (load, store or instruction fetch), whether the access comes from user mode, the make-executable-readable and supervisor-user-access controls, and the physical page number of the root table. The walker then issues 8-byte reads on a plain valid/ready request channel with a separate response strobe, starting at the top level (2) and descending towards level 0.

Each fetched 64-bit entry is decoded as: extension field in bits 63..54, physical page number in bits 53..10, two software bits in 9..8, and an attribute byte in 7..0 with D=7, A=6, G=5, U=4, X=3, W=2, R=1, V=0. A walk ends with a single-cycle completion pulse that carries either a physical address, the level of the leaf and a global flag, or a failure code. When the leaf's accessed or dirty flag has to be set, the walker writes the whole updated entry back to the address it was read from, but only when the platform update enable allows it.

Top module: `ptw39`

## Requirements
- R1: After reset, busy, done and mem_req_valid are all low.
- R2: The first read of a walk goes to root_ppn*4096 + vaddr[38:30]*8.
- R3: An entry with V=1 and R=W=X=0 above level 0 is a pointer: the next read goes to entry_ppn*4096 + (next level's 9-bit virtual page number slice)*8.
- R4: An entry with V=0, or with W=1 and R=0, ends the walk with code 1 (invalid) at any level; done_level reports the level reached.
- R5: A pointer entry read at level 0 ends the walk with code 2 without any further read.
- R6: A leaf is checked against access rules: user mode needs U=1; supervisor mode needs U=0 or sum=1 for loads and stores and U=0 for fetches; loads need R, or X with mxr=1; stores need W; fetches need X. A failed check ends with code 3.
- R7: A leaf at level 1 or 2 whose page number has any nonzero bit in the low 9 (level 1) or 18 (level 2) positions ends with code 4.
- R8: On success (code 0, done_fault low) done_paddr is the leaf page number shifted left by 12 with the low 12+9*level bits replaced by the virtual address bits, and done_level is the leaf level.
- R9: done_global is the OR of the G bits of every entry visited in the walk.
- R10: If the leaf has A=0, or the access is a store and D=0, and upd_en is low, the walk ends with code 5 and no write is issued.
- R11: If such an update is needed and upd_en is high, exactly one 8-byte write goes to the leaf's own address, carrying the original entry with A set (and D set for a store) and all other bits unchanged; success is reported only after that write is acknowledged. No write happens when no update is needed.
- R12: busy rises on acceptance and stays high until the cycle of a one-cycle done pulse, in which busy is low; requests offered while busy are ignored, and no memory request is made while idle.
- R13: While mem_req_valid is high and mem_req_ready is low, the request, its address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when idle |
| req_vaddr | input | 39 | Virtual address to translate |
| req_access | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| req_user | input | 1 | 1 for a user-mode access, 0 for supervisor |
| req_mxr | input | 1 | Lets loads use execute-only pages |
| req_sum | input | 1 | Lets supervisor loads and stores use user pages |
| req_root_ppn | input | 44 | Physical page number of the top-level table |
| upd_en | input | 1 | Allows accessed/dirty write-back, sampled at the leaf |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 56 | Byte address of the 8-byte entry |
| mem_req_wdata | output | 64 | Entry data for a write |
| mem_rsp_valid | input | 1 | Response strobe (read data or write acknowledge) |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk failed |
| done_code | output | 3 | 0 ok, 1 invalid, 2 pointer at level 0, 3 denied, 4 misaligned, 5 update disabled |
| done_paddr | output | 56 | Translated physical address (0 on failure) |
| done_level | output | 2 | Level at which the walk ended |
| done_global | output | 1 | OR of visited G bits |

## Verification
The assertions watch, on every cycle, the handshake contract: the done pulse lasting one cycle, busy falling only with done, no memory traffic while idle, a stalled request holding its address and data, and every write-back carrying the accessed flag. Which address each level reads, the decoding of invalid and pointer entries, the permission matrix, superpage alignment, the physical address composition, the accumulated global flag and whether a write-back happens at all depend on table contents, so only the directed scenarios with a modelled memory can show them.

// File: rtl/ptw39_pkg.sv
package ptw39_pkg;

  // attribute byte of a table entry, MSB first
  typedef struct packed {
    logic d;
    logic a;
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
    logic v;
  } attr_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    F_NONE     = 3'd0,
    F_INVALID  = 3'd1,
    F_PTR_LAST = 3'd2,
    F_DENIED   = 3'd3,
    F_MISALIGN = 3'd4,
    F_UPD_OFF  = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_RD_REQ  = 3'd1,
    S_RD_WAIT = 3'd2,
    S_EVAL    = 3'd3,
    S_WR_REQ  = 3'd4,
    S_WR_WAIT = 3'd5
  } state_e;

endpackage

// File: rtl/ptw39_perm.sv
module ptw39_perm
  import ptw39_pkg::*;
(
  input  attr_t attr,
  input  acc_e  access,
  input  logic  user,
  input  logic  mxr,
  input  logic  sum,
  output logic  bad_entry,
  output logic  is_ptr,
  output logic  allowed,
  output logic  need_upd,
  output attr_t new_attr
);

  logic is_store;
  logic is_fetch;
  logic rd_ok;
  logic kind_ok;
  logic mode_ok;

  assign is_store = (access == ACC_STORE);
  assign is_fetch = (access == ACC_FETCH);

  // reserved combination W without R counts as invalid
  assign bad_entry = !attr.v || (attr.w && !attr.r);
  assign is_ptr    = !attr.r && !attr.w && !attr.x;

  assign rd_ok = attr.r || (attr.x && mxr);

  always_comb begin
    if (is_fetch)      kind_ok = attr.x;
    else if (is_store) kind_ok = attr.w;
    else               kind_ok = rd_ok;
  end

  always_comb begin
    if (user)          mode_ok = attr.u;
    else if (is_fetch) mode_ok = !attr.u;
    else               mode_ok = !attr.u || sum;
  end

  assign allowed  = kind_ok && mode_ok;
  assign need_upd = !attr.a || (is_store && !attr.d);

  always_comb begin
    new_attr   = attr;
    new_attr.a = 1'b1;
    new_attr.d = attr.d || is_store;
  end

endmodule

// File: rtl/ptw39_addr.sv
module ptw39_addr #(
  parameter int LEVELS      = 3,
  parameter int VPN_BITS    = 9,
  parameter int PAGE_BITS   = 12,
  parameter int PPN_BITS    = 44,
  parameter int ENTRY_BYTES = 8,
  parameter int VA_BITS     = PAGE_BITS + LEVELS * VPN_BITS,
  parameter int PA_BITS     = PPN_BITS + PAGE_BITS,
  parameter int LVL_W       = $clog2(LEVELS)
) (
  input  logic [PA_BITS-1:0]  table_base,
  input  logic [VA_BITS-1:0]  vaddr,
  input  logic [LVL_W-1:0]    lvl,
  input  logic [PPN_BITS-1:0] leaf_ppn,
  output logic [PA_BITS-1:0]  ent_addr,
  output logic [PA_BITS-1:0]  leaf_paddr,
  output logic                sp_misaligned
);

  localparam int ESH = $clog2(ENTRY_BYTES);

  logic [PA_BITS-1:0] addr_c [LEVELS];
  logic [PA_BITS-1:0] pa_c   [LEVELS];
  logic               mis_c  [LEVELS];
  logic [PA_BITS-1:0] page_pa;

  assign page_pa = {leaf_ppn, {PAGE_BITS{1'b0}}};

  // one candidate per level; the walker's level picks one
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam int SH = PAGE_BITS + g * VPN_BITS;
    localparam logic [PA_BITS-1:0]  OFF_MASK = {PA_BITS{1'b1}} >> (PA_BITS - SH);
    localparam logic [PPN_BITS-1:0] SP_MASK  = {PPN_BITS{1'b1}} >> (PPN_BITS - g * VPN_BITS);
    logic [VPN_BITS-1:0] slice;
    assign slice     = vaddr[SH +: VPN_BITS];
    assign addr_c[g] = table_base + PA_BITS'({slice, {ESH{1'b0}}});
    assign pa_c[g]   = (page_pa & ~OFF_MASK) | (PA_BITS'(vaddr) & OFF_MASK);
    assign mis_c[g]  = |(leaf_ppn & SP_MASK);
  end

  always_comb begin
    ent_addr      = '0;
    leaf_paddr    = '0;
    sp_misaligned = 1'b0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i)) begin
        ent_addr      = addr_c[i];
        leaf_paddr    = pa_c[i];
        sp_misaligned = mis_c[i];
      end
    end
  end

endmodule

// File: rtl/ptw39.sv
module ptw39
  import ptw39_pkg::*;
#(
  parameter int LEVELS      = 3,
  parameter int VPN_BITS    = 9,
  parameter int PAGE_BITS   = 12,
  parameter int PPN_BITS    = 44,
  parameter int ENTRY_BYTES = 8,
  parameter int EXT_BITS    = 10,
  parameter int RSW_BITS    = 2,
  parameter int VA_BITS     = PAGE_BITS + LEVELS * VPN_BITS,
  parameter int PA_BITS     = PPN_BITS + PAGE_BITS,
  parameter int LVL_W       = $clog2(LEVELS),
  parameter int PTE_BITS    = EXT_BITS + PPN_BITS + RSW_BITS + 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [VA_BITS-1:0]  req_vaddr,
  input  logic [1:0]          req_access,
  input  logic                req_user,
  input  logic                req_mxr,
  input  logic                req_sum,
  input  logic [PPN_BITS-1:0] req_root_ppn,
  input  logic                upd_en,
  output logic                busy,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [PA_BITS-1:0]  mem_req_addr,
  output logic [PTE_BITS-1:0] mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [PTE_BITS-1:0] mem_rsp_data,
  output logic                done,
  output logic                done_fault,
  output logic [2:0]          done_code,
  output logic [PA_BITS-1:0]  done_paddr,
  output logic [LVL_W-1:0]    done_level,
  output logic                done_global
);

  localparam int PPN_LSB = 8 + RSW_BITS;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  state_e              state;
  logic [VA_BITS-1:0]  va_q;
  acc_e                acc_q;
  logic                user_q, mxr_q, sum_q;
  logic [PA_BITS-1:0]  base_q;
  logic [LVL_W-1:0]    lvl_q;
  logic [PTE_BITS-1:0] pte_q;
  logic                glob_q;
  logic [PTE_BITS-1:0] wdata_q;

  logic                busy_q, done_q, fault_q, glob_out_q;
  logic [2:0]          code_q;
  logic [PA_BITS-1:0]  paddr_q;
  logic [LVL_W-1:0]    level_q;

  attr_t               attr;
  logic [PPN_BITS-1:0] pte_ppn;
  logic                glob_n;
  logic                bad_entry, is_ptr, allowed, need_upd;
  attr_t               new_attr;
  logic [PA_BITS-1:0]  ent_addr, leaf_paddr;
  logic                sp_misaligned;

  assign attr    = attr_t'(pte_q[7:0]);
  assign pte_ppn = pte_q[PPN_LSB +: PPN_BITS];
  assign glob_n  = glob_q | attr.g;

  ptw39_perm i_perm (
    .attr      (attr),
    .access    (acc_q),
    .user      (user_q),
    .mxr       (mxr_q),
    .sum       (sum_q),
    .bad_entry (bad_entry),
    .is_ptr    (is_ptr),
    .allowed   (allowed),
    .need_upd  (need_upd),
    .new_attr  (new_attr)
  );

  ptw39_addr #(
    .LEVELS      (LEVELS),
    .VPN_BITS    (VPN_BITS),
    .PAGE_BITS   (PAGE_BITS),
    .PPN_BITS    (PPN_BITS),
    .ENTRY_BYTES (ENTRY_BYTES),
    .VA_BITS     (VA_BITS),
    .PA_BITS     (PA_BITS),
    .LVL_W       (LVL_W)
  ) i_addr (
    .table_base    (base_q),
    .vaddr         (va_q),
    .lvl           (lvl_q),
    .leaf_ppn      (pte_ppn),
    .ent_addr      (ent_addr),
    .leaf_paddr    (leaf_paddr),
    .sp_misaligned (sp_misaligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      va_q       <= '0;
      acc_q      <= ACC_LOAD;
      user_q     <= 1'b0;
      mxr_q      <= 1'b0;
      sum_q      <= 1'b0;
      base_q     <= '0;
      lvl_q      <= '0;
      pte_q      <= '0;
      glob_q     <= 1'b0;
      wdata_q    <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      code_q     <= F_NONE;
      paddr_q    <= '0;
      level_q    <= '0;
      glob_out_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            acc_q  <= acc_e'(req_access);
            user_q <= req_user;
            mxr_q  <= req_mxr;
            sum_q  <= req_sum;
            base_q <= {req_root_ppn, {PAGE_BITS{1'b0}}};
            lvl_q  <= TOP_LVL;
            glob_q <= 1'b0;
            busy_q <= 1'b1;
            state  <= S_RD_REQ;
          end
        end
        S_RD_REQ: begin
          if (mem_req_ready) state <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (mem_rsp_valid) begin
            pte_q <= mem_rsp_data;
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          glob_q <= glob_n;
          if (!bad_entry && is_ptr && lvl_q != '0) begin
            // descend one level
            base_q <= {pte_ppn, {PAGE_BITS{1'b0}}};
            lvl_q  <= lvl_q - 1'b1;
            state  <= S_RD_REQ;
          end else if (!bad_entry && !is_ptr && allowed && !sp_misaligned
                       && need_upd && upd_en) begin
            wdata_q    <= {pte_q[PTE_BITS-1:8], new_attr};
            paddr_q    <= leaf_paddr;
            level_q    <= lvl_q;
            glob_out_q <= glob_n;
            fault_q    <= 1'b0;
            code_q     <= F_NONE;
            state      <= S_WR_REQ;
          end else begin
            done_q     <= 1'b1;
            busy_q     <= 1'b0;
            level_q    <= lvl_q;
            glob_out_q <= glob_n;
            state      <= S_IDLE;
            fault_q    <= 1'b1;
            paddr_q    <= '0;
            if (bad_entry)          code_q <= F_INVALID;
            else if (is_ptr)        code_q <= F_PTR_LAST;
            else if (!allowed)      code_q <= F_DENIED;
            else if (sp_misaligned) code_q <= F_MISALIGN;
            else if (need_upd)      code_q <= F_UPD_OFF;
            else begin
              code_q  <= F_NONE;
              fault_q <= 1'b0;
              paddr_q <= leaf_paddr;
            end
          end
        end
        S_WR_REQ: begin
          if (mem_req_ready) state <= S_WR_WAIT;
        end
        S_WR_WAIT: begin
          if (mem_rsp_valid) begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == S_RD_REQ) || (state == S_WR_REQ);
  assign mem_req_write = (state == S_WR_REQ);
  assign mem_req_addr  = ent_addr;
  assign mem_req_wdata = wdata_q;

  assign busy        = busy_q;
  assign done        = done_q;
  assign done_fault  = fault_q;
  assign done_code   = code_q;
  assign done_paddr  = paddr_q;
  assign done_level  = level_q;
  assign done_global = glob_out_q;

  // completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // busy is already low while done is shown
  p_done_not_busy_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // busy only drops together with a completion
  p_busy_fall_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // no memory traffic outside a walk
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);

  // stalled request keeps its contents
  p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_wdata)));

  // a write-back always carries the accessed flag
  p_wb_accessed_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[6]);

endmodule

// File: tb/test_ptw39.sv
`timescale 1ns/1ps
module test_ptw39;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [38:0] req_vaddr = '0;
  logic [1:0]  req_access = '0;
  logic        req_user = 1'b0, req_mxr = 1'b0, req_sum = 1'b0;
  logic [43:0] req_root_ppn = '0;
  logic        upd_en = 1'b0;
  logic        busy, mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b1;
  logic [55:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done, done_fault, done_global;
  logic [2:0]  done_code;
  logic [55:0] done_paddr;
  logic [1:0]  done_level;

  always #4 clk = ~clk;

  ptw39 i_ptw39 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_access(req_access), .req_user(req_user), .req_mxr(req_mxr),
    .req_sum(req_sum), .req_root_ppn(req_root_ppn), .upd_en(upd_en),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
    .done_code(done_code), .done_paddr(done_paddr), .done_level(done_level),
    .done_global(done_global)
  );

  int n_checks = 0;
  int n_fail = 0;

  // memory model
  logic [63:0] mem_m [logic [55:0]];
  logic [55:0] rd_q [$];
  int          wr_n = 0;
  logic [55:0] wr_addr;
  logic [63:0] wr_data;
  int          stall_cnt = 0;

  always @(negedge clk) begin
    stall_cnt++;
    mem_req_ready = (stall_cnt % 3 != 0);
  end

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      mem_rsp_data <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_write) begin
        mem_m[mem_req_addr] = mem_req_wdata;
        wr_n++;
        wr_addr = mem_req_addr;
        wr_data = mem_req_wdata;
      end else begin
        mem_rsp_data <= mem_m.exists(mem_req_addr) ? mem_m[mem_req_addr] : 64'h0;
        rd_q.push_back(mem_req_addr);
      end
    end
  end

  // watchdog
  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  function automatic logic [63:0] ptr(input logic [43:0] ppn, input logic g);
    return {10'h0, ppn, 2'b00, 2'b00, g, 5'b00001};
  endfunction

  function automatic logic [63:0] leaf(input logic [9:0] ext, input logic [43:0] ppn, input logic [7:0] at);
    return {ext, ppn, 2'b00, at};
  endfunction

  function automatic logic [55:0] ea(input logic [43:0] ppn, input logic [8:0] vpn);
    return {ppn, 12'h0} + {44'h0, vpn, 3'b000};
  endfunction

  localparam logic [43:0] ROOT = 44'h100;
  localparam logic [38:0] VA   = {9'd1, 9'd2, 9'd3, 12'hABC};

  logic        r_fault, r_glob;
  logic [2:0]  r_code;
  logic [55:0] r_pa;
  logic [1:0]  r_lvl;

  task automatic go(input logic [38:0] va, input logic [1:0] acc, input logic usr,
                    input logic mx, input logic sm, input logic ue);
    int n;
    rd_q.delete();
    req_vaddr = va; req_access = acc; req_user = usr; req_mxr = mx; req_sum = sm;
    req_root_ppn = ROOT; upd_en = ue; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    r_fault = done_fault; r_code = done_code; r_pa = done_paddr;
    r_lvl = done_level; r_glob = done_global;
  endtask

  // standard chain L2 -> 0x200 -> 0x300 -> leaf at L0
  task automatic chain(input logic [63:0] l0, input logic g1);
    mem_m.delete();
    mem_m[ea(ROOT, 9'd1)] = ptr(44'h200, 1'b0);
    mem_m[ea(44'h200, 9'd2)] = ptr(44'h300, g1);
    mem_m[ea(44'h300, 9'd3)] = l0;
  endtask

  task automatic t_reset;
    eq("R1 busy", busy, 0);
    eq("R1 done", done, 0);
    eq("R1 mem_req_valid", mem_req_valid, 0);
  endtask

  task automatic t_4k;
    chain(leaf(10'h0, 44'h12345, 8'hCF), 1'b0);
    go(VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R2 first read", rd_q.size() > 0 ? rd_q[0] : 56'h0, ea(ROOT, 9'd1));
    eq("R3 second read", rd_q.size() > 1 ? rd_q[1] : 56'h0, ea(44'h200, 9'd2));
    eq("R3 third read", rd_q.size() > 2 ? rd_q[2] : 56'h0, ea(44'h300, 9'd3));
    eq("R13 read count under stalls", rd_q.size(), 3);
    eq("R8 fault", r_fault, 0);
    eq("R8 code", r_code, 0);
    eq("R8 paddr", r_pa, 56'h12345ABC);
    eq("R8 level", r_lvl, 0);
    eq("R9 global clear", r_glob, 0);
  endtask

  task automatic t_global;
    chain(leaf(10'h0, 44'h12345, 8'hCF), 1'b1);
    go(VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R9 global from pointer", r_glob, 1);
    eq("R9 still success", r_code, 0);
  endtask

  task automatic t_super;
    mem_m.delete();
    mem_m[ea(ROOT, 9'd1)] = leaf(10'h0, 44'h40000, 8'hC3);
    go({9'd1, 9'd5, 9'd7, 12'h123}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R8 giga paddr", r_pa, 56'h40A07123);
    eq("R8 giga level", r_lvl, 2);
    eq("R8 giga code", r_code, 0);
    mem_m[ea(ROOT, 9'd1)] = leaf(10'h0, 44'h40200, 8'hC3);
    go({9'd1, 9'd5, 9'd7, 12'h123}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R7 giga misaligned", r_code, 4);
    eq("R7 fault flag", r_fault, 1);
    mem_m[ea(ROOT, 9'd1)] = ptr(44'h200, 1'b0);
    mem_m[ea(44'h200, 9'd2)] = leaf(10'h0, 44'h201, 8'hC3);
    go(VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R7 mega misaligned", r_code, 4);
    eq("R7 mega level", r_lvl, 1);
  endtask

  task automatic t_invalid;
    mem_m.delete();
    go(VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R4 V=0 code", r_code, 1);
    eq("R4 V=0 level", r_lvl, 2);
    eq("R4 single read", rd_q.size(), 1);
    mem_m[ea(ROOT, 9'd1)] = ptr(44'h200, 1'b0);
    mem_m[ea(44'h200, 9'd2)] = leaf(10'h0, 44'h0, 8'h05);
    go(VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R4 W-only code", r_code, 1);
    eq("R4 W-only level", r_lvl, 1);
  endtask

  task automatic t_ptr_last;
    chain(ptr(44'h400, 1'b0), 1'b0);
    go(VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R5 code", r_code, 2);
    eq("R5 no extra read", rd_q.size(), 3);
  endtask

  task automatic t_perm;
    chain(leaf(10'h0, 44'h5, 8'hC3), 1'b0);
    go(VA, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    eq("R6 user on supervisor page", r_code, 3);
    chain(leaf(10'h0, 44'h5, 8'hD3), 1'b0);
    go(VA, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    eq("R6 user on user page", r_code, 0);
    go(VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R6 supervisor user page sum=0", r_code, 3);
    go(VA, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    eq("R6 supervisor user page sum=1", r_code, 0);
    chain(leaf(10'h0, 44'h5, 8'hC9), 1'b0);
    go(VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R6 exec-only load mxr=0", r_code, 3);
    go(VA, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    eq("R6 exec-only load mxr=1", r_code, 0);
    chain(leaf(10'h0, 44'h5, 8'hD9), 1'b0);
    go(VA, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
    eq("R6 supervisor fetch user page", r_code, 3);
    chain(leaf(10'h0, 44'h5, 8'hC3), 1'b0);
    go(VA, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R6 store to read-only", r_code, 3);
  endtask

  task automatic t_upd_off;
    int w0;
    chain(leaf(10'h0, 44'h12345, 8'h8F), 1'b0);
    w0 = wr_n;
    go(VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    eq("R10 code", r_code, 5);
    eq("R10 no write", wr_n - w0, 0);
  endtask

  task automatic t_upd_on;
    int w0;
    logic [63:0] orig;
    orig = {10'h2AB, 44'h12345, 2'b10, 8'h07};
    chain(orig, 1'b0);
    w0 = wr_n;
    go(VA, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R11 one write", wr_n - w0, 1);
    eq("R11 write addr", wr_addr, ea(44'h300, 9'd3));
    eq("R11 write data", wr_data, orig | 64'hC0);
    eq("R11 success", r_code, 0);
    eq("R11 paddr", r_pa, 56'h12345ABC);
    chain(leaf(10'h0, 44'h12345, 8'h4F), 1'b0);
    w0 = wr_n;
    go(VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    eq("R11 load with A set needs no write", wr_n - w0, 0);
    eq("R11 load code", r_code, 0);
  endtask

  task automatic t_busy;
    int n;
    chain(leaf(10'h0, 44'h12345, 8'hCF), 1'b0);
    rd_q.delete();
    req_vaddr = VA; req_access = 2'd0; req_user = 1'b0; req_mxr = 1'b0;
    req_sum = 1'b0; req_root_ppn = ROOT; upd_en = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    eq("R12 busy after accept", busy, 1);
    @(negedge clk);
    req_vaddr = {9'd7, 9'd7, 9'd7, 12'h0}; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 500) begin
      eq("R12 busy during walk", busy, 1);
      @(negedge clk);
      n++;
    end
    eq("R12 busy low at done", busy, 0);
    eq("R12 result of first request", done_paddr, 56'h12345ABC);
    @(negedge clk);
    eq("R12 done is one cycle", done, 0);
    eq("R12 busy request ignored", rd_q.size(), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_4k();
    t_global();
    t_super();
    t_invalid();
    t_ptr_last();
    t_perm();
    t_upd_off();
    t_upd_on();
    t_busy();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule